// File: doc/BRIEF.md
# Quad DAC Serial Register Interface

This block is the digital front end of a four-channel 12-bit digital-to-analog converter. A host writes 16-bit words over a three-wire serial port made of an active-low chip select, a serial clock and a data line. The block does not use these pins as clocks. It samples them with its own system clock through synchronizers. It then rebuilds the effective shift clock as the OR of chip select and serial clock, and shifts one bit, MSB first, into a 16-bit input register on each rising edge of that OR.

An active-low, level-sensitive load input copies the 12-bit data field of the input register into one of four channel registers, selected by the two top bits of the word. An active-low clear forces all four channel registers to zero scale or midscale, chosen by a select input. While clear is low, the outputs show the clear level directly from the pins. After clear is released, the clear level stays until a later load copies the held or newly shifted word.

Top module: `qdac_serial_front`

## Requirements
- R1: After reset, all four channel outputs are 0x000 and the input register holds zero, so a load straight after reset writes 0x000.
- R2: The 16-bit word enters MSB first, one bit per rising edge of (serial clock OR chip select). Bits [15:14] are the channel address, bits [13:12] are ignored, and bits [11:0] are the data D11..D0.
- R3: A load writes the data field only to the channel given by the address: 00 selects output A, 01 selects B, 10 selects C and 11 selects D. The other channels keep their values.
- R4: If chip select rises while the serial clock is low, this counts as a rising edge and shifts the current data-line value in as one extra bit.
- R5: While load is low, the addressed channel follows the input register as it changes. When load goes high, the channel keeps its last value.
- R6: While clear is low, every channel reads 0x000 when the select input is 0 and 0x800 when it is 1. The outputs show this level at once from the pins.
- R7: After clear goes high, the channels keep the clear level until the next load. That load writes the word that was held in the input register before the clear.
- R8: While clear is high, changing the select input does not change any channel.
- R9: Clear takes priority over load: with both low, the channels hold the clear level.
- R10: Serial clock edges while chip select is high shift nothing into the input register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that samples all serial and control pins |
| rst_n | input | 1 | Active-low asynchronous reset |
| sclk_i | input | 1 | Serial clock from the host |
| csn_i | input | 1 | Active-low chip select |
| sdin_i | input | 1 | Serial data, MSB first |
| ldn_i | input | 1 | Active-low, level-sensitive load strobe |
| clrn_i | input | 1 | Active-low clear |
| clr_mid_i | input | 1 | Clear level select: 0 gives zero scale, 1 gives midscale |
| dac_a_o | output | 12 | Channel A register value |
| dac_b_o | output | 12 | Channel B register value |
| dac_c_o | output | 12 | Channel C register value |
| dac_d_o | output | 12 | Channel D register value |

## Verification
The pin synchronizers add two system-clock cycles. A shift therefore lands in the input register on the third clock edge after a pin change, and a load or a registered clear reaches the channel registers on the third or fourth edge. The clear override on the outputs is combinational and can be seen within the same cycle. The bench drives every pin change at a falling edge and then holds it for six cycles. It compares the outputs only at the end of that window, except for the immediate clear check, which it samples one time unit after the pin change.

// File: rtl/qdsr_pkg.sv
package qdsr_pkg;

   // Pin bundle carried through the synchronizer.
   typedef struct packed {
      logic clr_mid;
      logic clrn;
      logic ldn;
      logic sdin;
      logic csn;
      logic sclk;
   } pins_t;

   // Idle levels of the pins while reset is applied.
   localparam pins_t PINS_IDLE = '{clr_mid: 1'b0, clrn: 1'b1, ldn: 1'b1,
                                   sdin: 1'b0, csn: 1'b1, sclk: 1'b1};

   // Clear level as a 32-bit value. Callers truncate it to their data width.
   function automatic logic [31:0] clear_level(input logic mid, input int unsigned width);
      return mid ? (32'd1 << (width - 1)) : 32'd0;
   endfunction

endpackage

// File: rtl/qdsr_sync.sv
module qdsr_sync #(
   parameter int unsigned        W       = 6,
   parameter int unsigned        STAGES  = 2,
   parameter logic [W-1:0]       RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d_i,
   output logic [W-1:0] q_o
);

   if (STAGES < 2) begin : g_bad_stages
      $error("qdsr_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0][W-1:0] chain;

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[0] <= RST_VAL;
            else        chain[0] <= d_i;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[s] <= RST_VAL;
            else        chain[s] <= chain[s-1];
         end
      end
   end

   assign q_o = chain[STAGES-1];

endmodule

// File: rtl/qdsr_shifter.sv
module qdsr_shifter #(
   parameter int unsigned WORD_W = 16,
   parameter int unsigned ADDR_W = 2,
   parameter int unsigned DATA_W = 12
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sclk_s,
   input  logic              csn_s,
   input  logic              sdin_s,
   output logic [ADDR_W-1:0] addr_o,
   output logic [DATA_W-1:0] data_o
);

   if (WORD_W < ADDR_W + DATA_W) begin : g_bad_word
      $error("qdsr_shifter: WORD_W too small for address and data");
   end

   logic [WORD_W-1:0] sr;
   logic              eff_now;
   logic              eff_q;
   logic              shift_en;

   // The shift clock is the OR of select and serial clock.
   assign eff_now  = sclk_s | csn_s;
   assign shift_en = eff_now & ~eff_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) eff_q <= 1'b1;
      else        eff_q <= eff_now;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        sr <= '0;
      else if (shift_en) sr <= {sr[WORD_W-2:0], sdin_s};
   end

   assign addr_o = sr[WORD_W-1 -: ADDR_W];
   assign data_o = sr[DATA_W-1:0];

   // R2: a shift moves the word up one place and takes the data bit in at the LSB
   assert_shift_msb_first_R2: assert property (@(posedge clk) disable iff (!rst_n)
      shift_en |=> (sr[0] == $past(sdin_s)) && (sr[WORD_W-1:1] == $past(sr[WORD_W-2:0])));

   // R10: with select held high, the register cannot change
   assert_cs_high_no_shift_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (csn_s && eff_q) |=> $stable(sr));

endmodule

// File: rtl/qdsr_bank.sv
module qdsr_bank #(
   parameter int unsigned ADDR_W = 2,
   parameter int unsigned DATA_W = 12,
   localparam int unsigned NUM_CH = 1 << ADDR_W
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic [ADDR_W-1:0]              addr_i,
   input  logic [DATA_W-1:0]              data_i,
   input  logic                           ldn_s,
   input  logic                           clrn_s,
   input  logic                           clr_mid_s,
   output logic [NUM_CH-1:0][DATA_W-1:0]  ch_o
);

   import qdsr_pkg::*;

   if (DATA_W < 2 || DATA_W > 32) begin : g_bad_data
      $error("qdsr_bank: DATA_W out of range");
   end

   localparam logic [DATA_W-1:0] MID_CODE = DATA_W'(clear_level(1'b1, DATA_W));

   logic [DATA_W-1:0] clr_code;
   logic [NUM_CH-1:0] wr_en;

   assign clr_code = DATA_W'(clear_level(clr_mid_s, DATA_W));

   for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      assign wr_en[c] = clrn_s & ~ldn_s & (addr_i == ADDR_W'(c));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)          ch_o[c] <= '0;
         else if (!clrn_s)    ch_o[c] <= clr_code;
         else if (wr_en[c])   ch_o[c] <= data_i;
      end

      // R6: a clear writes the level chosen by the select input
      assert_clear_level_R6: assert property (@(posedge clk) disable iff (!rst_n)
         !clrn_s |=> (ch_o[c] == ($past(clr_mid_s) ? MID_CODE : '0)));

      // R7: without clear and without a load of this channel, the value holds
      assert_hold_no_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
         (clrn_s && (ldn_s || addr_i != ADDR_W'(c))) |=> $stable(ch_o[c]));

      // R5: an active load of this channel copies the current data field
      assert_track_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
         (clrn_s && !ldn_s && addr_i == ADDR_W'(c)) |=> (ch_o[c] == $past(data_i)));
   end

   // R3: at most one channel is written at a time
   assert_one_channel_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(wr_en));

   // R9: with clear low, no channel is written from the data field
   assert_clear_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !clrn_s |-> (wr_en == '0));

endmodule

// File: rtl/qdac_serial_front.sv
module qdac_serial_front #(
   parameter int unsigned DATA_W        = 12,
   parameter int unsigned ADDR_W        = 2,
   parameter int unsigned PAD_W         = 2,
   parameter int unsigned SYNC_STAGES   = 2,
   parameter bit          ASYNC_CLR_OUT = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sclk_i,
   input  logic              csn_i,
   input  logic              sdin_i,
   input  logic              ldn_i,
   input  logic              clrn_i,
   input  logic              clr_mid_i,
   output logic [DATA_W-1:0] dac_a_o,
   output logic [DATA_W-1:0] dac_b_o,
   output logic [DATA_W-1:0] dac_c_o,
   output logic [DATA_W-1:0] dac_d_o
);

   import qdsr_pkg::*;

   localparam int unsigned WORD_W = ADDR_W + PAD_W + DATA_W;
   localparam int unsigned NUM_CH = 1 << ADDR_W;
   localparam int unsigned PIN_W  = $bits(pins_t);

   if (ADDR_W != 2) begin : g_bad_addr
      $error("qdac_serial_front: four output ports need ADDR_W of 2");
   end

   pins_t raw_pins;
   pins_t syn_pins;

   assign raw_pins = '{clr_mid: clr_mid_i, clrn: clrn_i, ldn: ldn_i,
                       sdin: sdin_i, csn: csn_i, sclk: sclk_i};

   qdsr_sync #(
      .W       (PIN_W),
      .STAGES  (SYNC_STAGES),
      .RST_VAL (PINS_IDLE)
   ) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   (raw_pins),
      .q_o   (syn_pins)
   );

   logic [ADDR_W-1:0] word_addr;
   logic [DATA_W-1:0] word_data;

   qdsr_shifter #(
      .WORD_W (WORD_W),
      .ADDR_W (ADDR_W),
      .DATA_W (DATA_W)
   ) u_shift (
      .clk    (clk),
      .rst_n  (rst_n),
      .sclk_s (syn_pins.sclk),
      .csn_s  (syn_pins.csn),
      .sdin_s (syn_pins.sdin),
      .addr_o (word_addr),
      .data_o (word_data)
   );

   logic [NUM_CH-1:0][DATA_W-1:0] ch_q;

   qdsr_bank #(
      .ADDR_W (ADDR_W),
      .DATA_W (DATA_W)
   ) u_bank (
      .clk       (clk),
      .rst_n     (rst_n),
      .addr_i    (word_addr),
      .data_i    (word_data),
      .ldn_s     (syn_pins.ldn),
      .clrn_s    (syn_pins.clrn),
      .clr_mid_s (syn_pins.clr_mid),
      .ch_o      (ch_q)
   );

   logic [NUM_CH-1:0][DATA_W-1:0] ch_out;

   if (ASYNC_CLR_OUT) begin : g_async_clr
      logic [DATA_W-1:0] pin_level;
      assign pin_level = DATA_W'(clear_level(clr_mid_i, DATA_W));
      for (genvar c = 0; c < NUM_CH; c++) begin : g_ovr
         assign ch_out[c] = clrn_i ? ch_q[c] : pin_level;
      end
   end else begin : g_sync_clr
      assign ch_out = ch_q;
   end

   assign dac_a_o = ch_out[0];
   assign dac_b_o = ch_out[1];
   assign dac_c_o = ch_out[2];
   assign dac_d_o = ch_out[3];

endmodule

// File: tb/tb_qdac_serial_front.sv
module tb_qdac_serial_front;

   localparam int PH  = 6;
   localparam int MID = 12'h800;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic sclk_i = 1'b1, csn_i = 1'b1, sdin_i = 1'b0;
   logic ldn_i = 1'b1, clrn_i = 1'b1, clr_mid_i = 1'b0;
   logic [11:0] dac_a_o, dac_b_o, dac_c_o, dac_d_o;

   always #5 clk = ~clk;

   qdac_serial_front dut (
      .clk(clk), .rst_n(rst_n), .sclk_i(sclk_i), .csn_i(csn_i), .sdin_i(sdin_i),
      .ldn_i(ldn_i), .clrn_i(clrn_i), .clr_mid_i(clr_mid_i),
      .dac_a_o(dac_a_o), .dac_b_o(dac_b_o), .dac_c_o(dac_c_o), .dac_d_o(dac_d_o)
   );

   int total = 0;
   int bad   = 0;
   bit finished = 1'b0;

   // Pin plan and reference model.
   logic p_sclk = 1'b1, p_csn = 1'b1, p_sdin = 1'b0, p_ldn = 1'b1, p_clrn = 1'b1, p_sel = 1'b0;
   logic m_eff = 1'b1;
   logic [15:0] m_sr = '0;
   logic [11:0] m_ch [4] = '{12'h0, 12'h0, 12'h0, 12'h0};

   function automatic logic [11:0] out_of(input int c);
      case (c)
         0: return dac_a_o;
         1: return dac_b_o;
         2: return dac_c_o;
         default: return dac_d_o;
      endcase
   endfunction

   task automatic check(input string tag, input logic [11:0] act, input logic [11:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic check_all(input string tag);
      for (int c = 0; c < 4; c++) check(tag, out_of(c), m_ch[c]);
   endtask

   task automatic step();
      @(negedge clk);
      sclk_i = p_sclk; csn_i = p_csn; sdin_i = p_sdin;
      ldn_i = p_ldn; clrn_i = p_clrn; clr_mid_i = p_sel;
      if (!m_eff && (p_sclk | p_csn)) m_sr = {m_sr[14:0], p_sdin};
      m_eff = p_sclk | p_csn;
      if (!p_clrn) begin
         for (int c = 0; c < 4; c++) m_ch[c] = p_sel ? 12'(MID) : 12'h000;
      end else if (!p_ldn) begin
         m_ch[m_sr[15:14]] = m_sr[11:0];
      end
      repeat (PH) @(negedge clk);
   endtask

   task automatic send_word(input logic [15:0] w);
      p_csn = 1'b0; step();
      for (int i = 15; i >= 0; i--) begin
         p_sclk = 1'b0; p_sdin = w[i]; step();
         p_sclk = 1'b1; step();
      end
      p_csn = 1'b1; step();
   endtask

   task automatic pulse_load();
      p_ldn = 1'b0; step();
      p_ldn = 1'b1; step();
   endtask

   task automatic do_clear(input logic sel);
      p_sel = sel; step();
      p_clrn = 1'b0; step();
      p_clrn = 1'b1; step();
   endtask

   initial begin : watchdog
      repeat (190000) @(posedge clk);
      if (!finished) begin
         finished = 1'b1;
         total++; bad++;
         $display("FAIL watchdog: actual=timeout expected=done");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin : main
      logic [11:0] held;
      logic [31:0] r;
      r = $urandom(32'd2024);
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      repeat (4) @(negedge clk);

      // R1 reset state, then a load of the empty register
      check_all("R1 reset");
      pulse_load();
      check_all("R1 load after reset");

      // R3 each address in turn, R2 ignored bits set
      send_word(16'h3ABC); pulse_load(); check_all("R3 addr A / R2 pad ignored");
      check("R2 data field", dac_a_o, 12'hABC);
      send_word(16'h4123); pulse_load(); check_all("R3 addr B");
      send_word(16'hB456); pulse_load(); check_all("R3 addr C");
      check("R3 C value", dac_c_o, 12'h456);
      send_word(16'hC789); pulse_load(); check_all("R3 addr D");
      check("R3 D value", dac_d_o, 12'h789);

      // R10 serial clock toggles with select high shift nothing
      for (int i = 0; i < 5; i++) begin
         p_sdin = 1'b1; p_sclk = 1'b0; step();
         p_sclk = 1'b1; step();
      end
      pulse_load();
      check("R10 no shift with cs high", dac_d_o, 12'h789);
      check_all("R10");

      // R4 select rises with serial clock low: extra bit
      p_csn = 1'b0; step();
      for (int i = 15; i >= 0; i--) begin
         p_sclk = 1'b0; p_sdin = 16'h1234 >> i; step();
         p_sclk = 1'b1; step();
      end
      p_sclk = 1'b0; p_sdin = 1'b1; step();
      p_csn = 1'b1; step();
      p_sclk = 1'b1; step();
      pulse_load();
      // word becomes 0x2469: address 00, data 0x469
      check("R4 false bit", dac_a_o, 12'h469);
      check_all("R4");

      // R5 load held low while a word shifts in
      p_ldn = 1'b0; step();
      send_word(16'h8E01);
      check("R5 tracking", dac_c_o, 12'hE01);
      check_all("R5 track");
      p_ldn = 1'b1; step();
      send_word(16'h8F00);
      check("R5 keep after release", dac_c_o, 12'hE01);
      check_all("R5 keep");

      // R6 immediate clear at the outputs
      held = m_sr[11:0];
      p_sel = 1'b1; step();
      @(negedge clk);
      clrn_i = 1'b0;
      #1;
      check("R6 immediate mid", dac_b_o, 12'h800);
      p_clrn = 1'b0; step();
      check_all("R6 mid");
      p_sel = 1'b0; step();
      check_all("R6 zero");
      check("R6 zero value", dac_c_o, 12'h000);

      // R9 load during clear keeps the clear level
      pulse_load();
      check_all("R9 clear wins");
      p_clrn = 1'b1; step();

      // R7 clear level kept, then held word restored
      check_all("R7 hold after clear");
      // R8 select toggles with clear high
      p_sel = 1'b1; step();
      p_sel = 1'b0; step();
      check_all("R8 select ignored");
      check("R8 A", dac_a_o, 12'h000);
      pulse_load();
      check("R7 held word reload", dac_c_o, held);
      check_all("R7 reload");

      // Random words to random channels, with occasional clears
      for (int n = 0; n < 40; n++) begin
         send_word(16'($urandom));
         pulse_load();
         check_all("R3 random");
         if (n % 9 == 8) begin
            do_clear(1'($urandom));
            check_all("R6 random clear");
         end
      end

      finished = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule